// File: doc/BRIEF.md
# Jiffy Timer with Seconds Alarm

This block turns the system clock into a periodic jiffy tick, nominally 10 ms. Every jiffy advances a free-running uptime counter. It also drives a second prescaler that feeds a down-counting alarm, which holds a whole number of seconds. A host loads the alarm through a small register port. When the count runs out, the block raises a sticky alarm event and disarms itself. Host software can use that event to abandon an operation that has hung.

Writing a non-zero number of seconds arms the alarm. The same write restarts the second prescaler, so the first second is a full second. Writing zero cancels a pending alarm, and the event does not fire. The uptime counter can be read at any time. The alarm event stays set until the host clears it.

The register map has three readable words:
- Address 0 is the uptime count, zero-extended.
- Address 1 is the number of seconds left on the alarm. Writes to it load the alarm.
- Address 2 is status. Bit 0 is the alarm event and bit 1 is armed. Writing 1 to bit 0 clears the event.

Address 3 reads as zero. Reads are combinational from `reg_addr`.

Top module: `jiffy_alarm_timer`

## Requirements
- R1: `jiffy_pulse` is high for exactly one clock cycle out of every `CLK_PER_JIFFY` cycles.
- R2: The uptime counter, read at address 0, rises by exactly one for each jiffy pulse and is otherwise unchanged.
- R3: The uptime counter is `UPTIME_W` bits wide (32 by default). After all ones it wraps to zero, and the wrap has no other effect.
- R4: Writing a non-zero value to address 1 performs three actions:
  - it loads `reg_wdata[ALARM_W-1:0]` as the remaining seconds;
  - it sets the armed bit (status bit 1);
  - it restarts the second prescaler, even if the alarm was already armed.
- R5: While armed, the remaining seconds read at address 1 drop by one after every `JIFFY_PER_SEC` jiffies counted from the load.
- R6: After a load of V seconds, the alarm fires exactly V×`JIFFY_PER_SEC` jiffies after the load. Firing has three effects:
  - the event sets (status bit 0, output `alarm_event`);
  - armed clears;
  - remaining seconds read zero.
- R7: Writing zero to address 1 disarms a pending alarm and zeroes the remaining seconds, and the event does not fire.
- R8: The event flag stays set until a write to address 2 with bit 0 equal to 1. A write to address 2 with bit 0 equal to 0 leaves the flag unchanged.
- R9: After reset, these are all zero:
  - uptime, remaining seconds and status;
  - `alarm_event` and `alarm_armed`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register address (0 uptime, 1 alarm, 2 status) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| jiffy_pulse | output | 1 | One-cycle pulse per jiffy |
| alarm_event | output | 1 | Sticky alarm-fired flag |
| alarm_armed | output | 1 | Alarm is counting down |

## Verification
The bound checker covers the local, cycle-to-cycle rules on every cycle:
- the jiffy pulse lasts one cycle;
- uptime changes only on a jiffy and only by one;
- the count steps down only on a second strobe;
- firing leaves the alarm disarmed with the flag set;
- a zero write disarms;
- the flag holds until cleared.

Other properties span many cycles, and only the bench's scenarios can show them:
- the exact spacing of jiffies;
- the total number of jiffies from a load to the event;
- the prescaler restart when the alarm is re-armed mid-second;
- a cancelled alarm staying silent long after its deadline;
- the uptime wrap.

// File: rtl/jt_pkg.sv
package jt_pkg;
  localparam int unsigned JT_BUS_W = 32;

  typedef enum logic [1:0] {
    JT_REG_UPTIME = 2'd0,
    JT_REG_ALARM  = 2'd1,
    JT_REG_STATUS = 2'd2,
    JT_REG_SPARE  = 2'd3
  } jt_reg_e;

  localparam int unsigned JT_ST_EVENT_BIT = 0;
  localparam int unsigned JT_ST_ARMED_BIT = 1;
endpackage

// File: rtl/jt_divider.sv
// Modulo-LIMIT counter: advances on step, returns to zero on restart,
// and flags the step that completes a full cycle.
module jt_divider #(
  parameter int unsigned LIMIT = 100,
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic step,
  output logic wrap
);
  logic [CW-1:0] cnt_q;

  function automatic logic at_last(logic [CW-1:0] c);
    return c == CW'(LIMIT - 1);
  endfunction

  function automatic logic [CW-1:0] advance(logic [CW-1:0] c);
    return at_last(c) ? '0 : c + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (step)    cnt_q <= advance(cnt_q);
  end

  assign wrap = step && at_last(cnt_q);
endmodule

// File: rtl/jt_uptime.sv
module jt_uptime #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  output logic [W-1:0] value
);
  function automatic logic [W-1:0] bump(logic [W-1:0] v);
    return v + 1'b1;  // natural modulo-2^W wrap
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)    value <= '0;
    else if (tick) value <= bump(value);
  end
endmodule

// File: rtl/jt_alarm.sv
module jt_alarm #(
  parameter int unsigned ALARM_W       = 16,
  parameter int unsigned JIFFY_PER_SEC = 100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               jiffy_tick,
  input  logic               load_en,
  input  logic [ALARM_W-1:0] load_val,
  input  logic               flag_clear,
  output logic [ALARM_W-1:0] count,
  output logic               armed,
  output logic               flag,
  output logic               sec_strobe,
  output logic               fire
);
  logic load_nonzero;

  function automatic logic last_second(logic [ALARM_W-1:0] c);
    return c == ALARM_W'(1);
  endfunction

  function automatic logic [ALARM_W-1:0] dec(logic [ALARM_W-1:0] c);
    return c - 1'b1;
  endfunction

  assign load_nonzero = |load_val;

  // Second prescaler: held at zero while idle, restarted by every load.
  jt_divider #(.LIMIT(JIFFY_PER_SEC)) u_sec_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (load_en || !armed),
    .step    (armed && jiffy_tick),
    .wrap    (sec_strobe)
  );

  assign fire = armed && sec_strobe && !load_en && last_second(count);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      armed <= 1'b0;
    end else if (load_en) begin
      count <= load_val;
      armed <= load_nonzero;
    end else if (sec_strobe) begin
      count <= dec(count);
      if (last_second(count)) armed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          flag <= 1'b0;
    else if (fire)       flag <= 1'b1;
    else if (flag_clear) flag <= 1'b0;
  end
endmodule

// File: rtl/jiffy_alarm_timer.sv
module jiffy_alarm_timer
  import jt_pkg::*;
#(
  parameter int unsigned CLK_PER_JIFFY = 1_250_000,
  parameter int unsigned JIFFY_PER_SEC = 100,
  parameter int unsigned UPTIME_W      = 32,
  parameter int unsigned ALARM_W       = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [1:0]          reg_addr,
  input  logic [JT_BUS_W-1:0] reg_wdata,
  output logic [JT_BUS_W-1:0] reg_rdata,
  output logic                jiffy_pulse,
  output logic                alarm_event,
  output logic                alarm_armed
);
  jt_reg_e              addr;
  logic                 jiffy_tick;
  logic                 sec_strobe;
  logic                 alarm_fire;
  logic                 alarm_load;
  logic                 load_zero;
  logic                 flag_clear;
  logic [UPTIME_W-1:0]  uptime;
  logic [ALARM_W-1:0]   alarm_count;
  logic [ALARM_W-1:0]   alarm_wval;
  logic                 unused_wdata;

  assign addr         = jt_reg_e'(reg_addr);
  assign alarm_load   = reg_wr && (addr == JT_REG_ALARM);
  assign alarm_wval   = reg_wdata[ALARM_W-1:0];
  assign load_zero    = alarm_load && (alarm_wval == '0);
  assign flag_clear   = reg_wr && (addr == JT_REG_STATUS) && reg_wdata[JT_ST_EVENT_BIT];
  assign unused_wdata = ^reg_wdata;

  jt_divider #(.LIMIT(CLK_PER_JIFFY)) u_jiffy_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (1'b0),
    .step    (1'b1),
    .wrap    (jiffy_tick)
  );

  jt_uptime #(.W(UPTIME_W)) u_uptime (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (jiffy_tick),
    .value (uptime)
  );

  jt_alarm #(.ALARM_W(ALARM_W), .JIFFY_PER_SEC(JIFFY_PER_SEC)) u_alarm (
    .clk        (clk),
    .rst_n      (rst_n),
    .jiffy_tick (jiffy_tick),
    .load_en    (alarm_load),
    .load_val   (alarm_wval),
    .flag_clear (flag_clear),
    .count      (alarm_count),
    .armed      (alarm_armed),
    .flag       (alarm_event),
    .sec_strobe (sec_strobe),
    .fire       (alarm_fire)
  );

  assign jiffy_pulse = jiffy_tick;

  always_comb begin
    reg_rdata = '0;
    case (addr)
      JT_REG_UPTIME: reg_rdata[UPTIME_W-1:0] = uptime;
      JT_REG_ALARM:  reg_rdata[ALARM_W-1:0]  = alarm_count;
      JT_REG_STATUS: begin
        reg_rdata[JT_ST_EVENT_BIT] = alarm_event;
        reg_rdata[JT_ST_ARMED_BIT] = alarm_armed;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/jt_checker.sv
module jt_checker #(
  parameter int unsigned UPTIME_W = 32,
  parameter int unsigned ALARM_W  = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                jiffy_tick,
  input logic [UPTIME_W-1:0] uptime,
  input logic                alarm_load,
  input logic                load_zero,
  input logic                sec_strobe,
  input logic                alarm_fire,
  input logic                armed,
  input logic [ALARM_W-1:0]  count,
  input logic                flag,
  input logic                flag_clear
);
  p_jiffy_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    jiffy_tick |=> !jiffy_tick);

  p_uptime_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    jiffy_tick |=> uptime == UPTIME_W'($past(uptime) + 1'b1));

  p_uptime_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !jiffy_tick |=> $stable(uptime));

  p_armed_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> count != '0);

  p_count_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_load && !sec_strobe |=> $stable(count));

  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sec_strobe && !alarm_load |=> count == ALARM_W'($past(count) - 1'b1));

  p_fire_disarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_fire |=> !armed && flag && count == '0);

  p_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_zero |=> !armed && count == '0);

  p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !flag_clear |=> flag);
endmodule

bind jiffy_alarm_timer jt_checker #(.UPTIME_W(UPTIME_W), .ALARM_W(ALARM_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .jiffy_tick (jiffy_tick),
  .uptime     (uptime),
  .alarm_load (alarm_load),
  .load_zero  (load_zero),
  .sec_strobe (sec_strobe),
  .alarm_fire (alarm_fire),
  .armed      (alarm_armed),
  .count      (alarm_count),
  .flag       (alarm_event),
  .flag_clear (flag_clear)
);

// File: tb/jiffy_alarm_timer_tb.sv
module jiffy_alarm_timer_tb;
  localparam int N  = 5;   // clocks per jiffy
  localparam int J  = 4;   // jiffies per second
  localparam int UW = 6;   // uptime width, small for the wrap test

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        jiffy_pulse, alarm_event, alarm_armed;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  int          exp_q[$];          // scoreboard: expected jiffies to fire
  int          tick_since = 0;
  int          cyc_since = 0;
  bit          seen_first = 1'b0;
  bit          flag_prev = 1'b0;
  logic [UW-1:0] up_model = '0;

  always #4 clk = ~clk;           // 125 MHz

  jiffy_alarm_timer #(.CLK_PER_JIFFY(N), .JIFFY_PER_SEC(J), .UPTIME_W(UW), .ALARM_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .jiffy_pulse(jiffy_pulse),
    .alarm_event(alarm_event), .alarm_armed(alarm_armed)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic arm(input int secs);
    exp_q.delete();
    if (secs != 0) exp_q.push_back(secs * J);
    write_reg(2'd1, 32'(secs));
  endtask

  task automatic wait_event(input int limit);
    int k;
    for (k = 0; k < limit; k++) begin
      @(negedge clk);
      if (alarm_event) break;
    end
    check(alarm_event, "R6", "alarm event within limit", alarm_event, 1);
  endtask

  // Monitor: jiffy spacing, uptime model, and scoreboard of alarm firing.
  always @(negedge clk) begin
    if (!rst_n) begin
      flag_prev <= 1'b0;
    end else begin
      flag_prev <= alarm_event;
      if (alarm_event && !flag_prev) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", "event with no pending alarm", 1, 0);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(tick_since == e, "R6", "jiffies from load to event", tick_since, e);
          check(!alarm_armed, "R6", "armed after event", alarm_armed, 0);
        end
      end
      if (reg_wr && reg_addr == 2'd1) tick_since <= 0;
      else if (jiffy_pulse) tick_since <= tick_since + 1;
      if (jiffy_pulse) begin
        up_model <= up_model + 1'b1;
        if (seen_first) check(cyc_since == N, "R1", "cycles between jiffies", cyc_since, N);
        seen_first <= 1'b1;
        cyc_since  <= 1;
      end else begin
        cyc_since <= cyc_since + 1;
      end
    end
  end

  initial begin
    #(200000 * 8);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] prev;
    bit wrap_seen;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R9: reset state
    read_reg(2'd0, d); check(d == 0, "R9", "uptime after reset", d, 0);
    read_reg(2'd1, d); check(d == 0, "R9", "alarm after reset", d, 0);
    read_reg(2'd2, d); check(d == 0, "R9", "status after reset", d, 0);
    check(!alarm_event && !alarm_armed, "R9", "event/armed after reset", {alarm_event, alarm_armed}, 0);
    read_reg(2'd3, d); check(d == 0, "R9", "spare address", d, 0);

    // R2: uptime follows jiffies
    repeat (3 * N) @(posedge clk);
    read_reg(2'd0, d); check(d == 32'(up_model), "R2", "uptime vs jiffies", d, up_model);

    // R4/R5/R6: arm 3 s
    arm(3);
    read_reg(2'd1, d); check(d == 3, "R4", "loaded seconds", d, 3);
    read_reg(2'd2, d); check(d == 32'h2, "R4", "status armed bit1", d, 2);
    repeat (J * N + 3) @(posedge clk);
    read_reg(2'd1, d); check(d == 2, "R5", "seconds after one second", d, 2);
    wait_event(3 * J * N + 4 * N);
    read_reg(2'd2, d); check(d == 32'h1, "R6", "status after fire", d, 1);
    read_reg(2'd1, d); check(d == 0, "R6", "seconds after fire", d, 0);

    // R8: sticky flag, clear only with bit0 = 1
    repeat (3 * N) @(posedge clk);
    write_reg(2'd2, 32'h0);
    read_reg(2'd2, d); check(d[0] == 1'b1, "R8", "flag after write of 0", d[0], 1);
    write_reg(2'd2, 32'h1);
    read_reg(2'd2, d); check(d[0] == 1'b0, "R8", "flag after clear", d[0], 0);

    // R7: cancel a pending alarm
    arm(2);
    repeat (2 * N) @(posedge clk);
    arm(0);
    read_reg(2'd2, d); check(d == 0, "R7", "status after cancel", d, 0);
    repeat (3 * J * N) @(posedge clk);
    read_reg(2'd2, d); check(d == 0, "R7", "no event after deadline", d, 0);
    read_reg(2'd1, d); check(d == 0, "R7", "seconds after cancel", d, 0);

    // R4: re-arm mid-second restarts the prescaler (monitor checks count)
    arm(2);
    repeat (3 * N) @(posedge clk);
    arm(1);
    wait_event(2 * J * N);
    write_reg(2'd2, 32'h1);

    // R6: a one-second alarm from idle
    arm(1);
    wait_event(2 * J * N);
    write_reg(2'd2, 32'h1);
    read_reg(2'd2, d); check(d == 0, "R8", "status after second clear", d, 0);

    // R2/R3: track uptime through a wrap
    wrap_seen = 1'b0;
    read_reg(2'd0, prev);
    for (int i = 0; i < 70 * N; i++) begin
      read_reg(2'd0, d);
      if (d != prev) check(d == 32'(up_model), "R2", "uptime tracking", d, up_model);
      if (prev == 32'((1 << UW) - 1) && d != prev) begin
        check(d == 0, "R3", "uptime wraps to zero", d, 0);
        wrap_seen = 1'b1;
      end
      prev = d;
    end
    check(wrap_seen, "R3", "wrap observed", wrap_seen, 1);
    check(!alarm_event && !alarm_armed, "R3", "wrap has no side effect", {alarm_event, alarm_armed}, 0);

    finish_run();
  end
endmodule